// File: doc/BRIEF.md
# UART Channel Register Bank with Indexed Extended Window

This block is the host-side register file of one enhanced UART channel. A host reaches it through a 3-bit address, separate write and read strobes and a byte data bus. It holds the channel's line, modem and FIFO control registers and the divisor latch. It forms the line status, interrupt status and modem status views from status inputs supplied by the serial datapath, and it drives the modem control pins and the break gate on the serial output.

Beyond the eight directly addressed locations, a second bank of control and identification registers sits behind an indexed window. The host writes an offset into the scratch location (address 7) and then writes to or reads from address 5. A read through the window returns the selected extended register only while the read-enable bit (bit 6) of the extended access-control register is set. Any window access is refused while the line control register holds the lock code 0xBF. The channel can be reset from software in two ways. Both restore every register except the two clock-source selections.

Top module: `uart_regbank`

## Requirements
- R1: After hardware reset every writable register reads 0x00, except the divisor low byte, which reads 0x01 (address 0 with line control bit 7 set), and the prescaler at extended offset 0x01, which reads 0x20.
- R2: Address 5 reads line status {0, thr_empty_i AND tsr_empty_i, thr_empty_i, 0000, rx_ready_i}, which is 0x60 with an idle datapath. Address 2 reads {0000000, NOT irq_i}.
- R3: Through the window, offset 0x05 reads the receive level and offset 0x06 reads the transmit level, each zero-extended. Offset 0x08 reads the constant 0x01 and offset 0x09 reads the constant 0x02. Offset 0x07 and every offset above 0x0A read 0x00.
- R4: While line control bit 7 is set, addresses 0 and 1 access the divisor low and high bytes, which appear on divisor_o. While it is clear, address 1 holds the interrupt enable byte, a write to address 0 asserts tx_wr_o, and a read of address 0 returns rx_data_i and asserts rx_rd_o.
- R5: Writing an offset to address 7 and then data to address 5 updates the selected extended register, and address 7 reads back its own value. While line control holds 0xBF, a write to address 5 changes nothing.
- R6: Address 5 returns the extended register only when access-control bit 6 is set and line control is not 0xBF. Otherwise it returns line status.
- R7: Writing a value with bit 7 set to the options register (extended offset 0x0A) resets every register to its R1 value, except the clock-select registers at offsets 0x03 and 0x04.
- R8: Writing 0x00 to extended offset 0x07 performs the same software reset as R7. Writing any other value there has no effect.
- R9: dtr_o equals NOT modem-control bit 0 and rts_o equals NOT modem-control bit 1. sout_o equals tx_serial_i AND NOT line-control bit 6. All three are high after reset.
- R10: Address 6 reads the inverted active-low modem pins {dcd, ri, dsr, cts} (modem_ni[3:0]) in bits 7:4, two clock edges after a pin change, with bits 3:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Host register address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| rx_data_i | input | 8 | Byte at the head of the receive queue |
| rx_ready_i | input | 1 | Receive data available |
| thr_empty_i | input | 1 | Transmit holding queue empty |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| irq_i | input | 1 | Interrupt pending from the priority logic |
| rfl_i | input | 7 | Receive queue level |
| tfl_i | input | 7 | Transmit queue level |
| modem_ni | input | 4 | Active-low modem pins {dcd, ri, dsr, cts} |
| tx_serial_i | input | 1 | Serial stream from the transmitter |
| tx_wr_o | output | 1 | Push wdata_i into the transmit queue |
| rx_rd_o | output | 1 | Pop the receive queue |
| sout_o | output | 1 | Serial output after the break gate |
| dtr_o | output | 1 | Data terminal ready, active low |
| rts_o | output | 1 | Request to send, active low |
| divisor_o | output | 16 | Baud divisor {high, low} |
| prescale_o | output | 8 | Clock prescaler |
| clk_sel_o | output | 8 | Clock source selection |
| line_ctl_o | output | 8 | Line control register |
| fifo_ctl_o | output | 8 | FIFO control register |
| int_en_o | output | 8 | Interrupt enable register |

## Verification
The hardest state to reach is a software reset that must spare the clock-select registers. The bench first loads distinctive values into those registers and into their neighbours through the window. It then triggers each reset path and reopens the read window, which the reset has closed, to show the two kept values alongside restored defaults. A second hard case is the lock code. The bench writes through the window while line control holds 0xBF, then unlocks and reads the target back to prove the write was refused.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_IER  = 3'd1,
    A_ISR  = 3'd2,
    A_LCR  = 3'd3,
    A_MCR  = 3'd4,
    A_WIN  = 3'd5,
    A_MSR  = 3'd6,
    A_SPR  = 3'd7
  } host_addr_e;

  localparam logic [DW-1:0] X_ACR = 8'h00;
  localparam logic [DW-1:0] X_CPR = 8'h01;
  localparam logic [DW-1:0] X_TCR = 8'h02;
  localparam logic [DW-1:0] X_CKS = 8'h03;
  localparam logic [DW-1:0] X_CKA = 8'h04;
  localparam logic [DW-1:0] X_RFL = 8'h05;
  localparam logic [DW-1:0] X_TFL = 8'h06;
  localparam logic [DW-1:0] X_CSR = 8'h07;
  localparam logic [DW-1:0] X_GID = 8'h08;
  localparam logic [DW-1:0] X_DID = 8'h09;
  localparam logic [DW-1:0] X_OPT = 8'h0A;

  localparam logic [DW-1:0] DLL_RST  = 8'h01;
  localparam logic [DW-1:0] CPR_RST  = 8'h20;
  localparam logic [DW-1:0] GID_VAL  = 8'h01;
  localparam logic [DW-1:0] DID_VAL  = 8'h02;
  localparam logic [DW-1:0] LCR_LOCK = 8'hBF;
  localparam int unsigned   ACR_RDEN = 6;
  localparam int unsigned   OPT_SRST = 7;
  localparam int unsigned   LCR_DLAB = 7;
  localparam int unsigned   LCR_BRK  = 6;

  typedef struct packed {
    logic dll;
    logic dlm;
    logic ier;
    logic fcr;
    logic lcr;
    logic mcr;
    logic win;
    logic spr;
    logic tx;
    logic rx;
  } hstrobe_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       dlab_i,
  input  logic       lock_i,
  output hstrobe_t   stb_o
);
  host_addr_e a;
  assign a = host_addr_e'(addr_i);

  always_comb begin
    stb_o     = '0;
    stb_o.dll = wr_i && a == A_DATA && dlab_i;
    stb_o.tx  = wr_i && a == A_DATA && !dlab_i;
    stb_o.rx  = rd_i && a == A_DATA && !dlab_i;
    stb_o.dlm = wr_i && a == A_IER && dlab_i;
    stb_o.ier = wr_i && a == A_IER && !dlab_i;
    stb_o.fcr = wr_i && a == A_ISR;
    stb_o.lcr = wr_i && a == A_LCR;
    stb_o.mcr = wr_i && a == A_MCR;
    stb_o.win = wr_i && a == A_WIN && !lock_i;
    stb_o.spr = wr_i && a == A_SPR;
  end
endmodule

// File: rtl/uart_rb_sync.sv
module uart_rb_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/uart_rb_ext.sv
module uart_rb_ext
  import uart_rb_pkg::*;
#(
  parameter int unsigned LEVEL_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DW-1:0]      off_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [LEVEL_W-1:0] rfl_i,
  input  logic [LEVEL_W-1:0] tfl_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rd_en_o,
  output logic [DW-1:0]      cpr_o,
  output logic [DW-1:0]      cks_o,
  output logic               soft_rst_o
);
  localparam int unsigned PAD = DW - LEVEL_W;

  logic [DW-1:0] acr_q, cpr_q, tcr_q, cks_q, cka_q, opt_q;

  // both software reset triggers act on the edge of the triggering write
  assign soft_rst_o = we_i && ((off_i == X_CSR && wdata_i == '0) ||
                               (off_i == X_OPT && wdata_i[OPT_SRST]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acr_q <= '0;
      cpr_q <= CPR_RST;
      tcr_q <= '0;
      opt_q <= '0;
    end else if (soft_rst_o) begin
      acr_q <= '0;
      cpr_q <= CPR_RST;
      tcr_q <= '0;
      opt_q <= '0;
    end else if (we_i) begin
      case (off_i)
        X_ACR:   acr_q <= wdata_i;
        X_CPR:   cpr_q <= wdata_i;
        X_TCR:   tcr_q <= wdata_i;
        X_OPT:   opt_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // clock source selections survive software reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cks_q <= '0;
      cka_q <= '0;
    end else if (we_i) begin
      if (off_i == X_CKS) cks_q <= wdata_i;
      if (off_i == X_CKA) cka_q <= wdata_i;
    end
  end

  always_comb begin
    case (off_i)
      X_ACR:   rdata_o = acr_q;
      X_CPR:   rdata_o = cpr_q;
      X_TCR:   rdata_o = tcr_q;
      X_CKS:   rdata_o = cks_q;
      X_CKA:   rdata_o = cka_q;
      X_RFL:   rdata_o = {{PAD{1'b0}}, rfl_i};
      X_TFL:   rdata_o = {{PAD{1'b0}}, tfl_i};
      X_GID:   rdata_o = GID_VAL;
      X_DID:   rdata_o = DID_VAL;
      X_OPT:   rdata_o = opt_q;
      default: rdata_o = '0;
    endcase
  end

  assign rd_en_o = acr_q[ACR_RDEN];
  assign cpr_o   = cpr_q;
  assign cks_o   = cks_q;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 7,
  parameter int unsigned MODEM_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_ready_i,
  input  logic               thr_empty_i,
  input  logic               tsr_empty_i,
  input  logic               irq_i,
  input  logic [LEVEL_W-1:0] rfl_i,
  input  logic [LEVEL_W-1:0] tfl_i,
  input  logic [MODEM_W-1:0] modem_ni,
  input  logic               tx_serial_i,
  output logic               tx_wr_o,
  output logic               rx_rd_o,
  output logic               sout_o,
  output logic               dtr_o,
  output logic               rts_o,
  output logic [15:0]        divisor_o,
  output logic [7:0]         prescale_o,
  output logic [7:0]         clk_sel_o,
  output logic [7:0]         line_ctl_o,
  output logic [7:0]         fifo_ctl_o,
  output logic [7:0]         int_en_o
);
  localparam int unsigned MSR_PAD = DW - MODEM_W;

  logic [DW-1:0] dll_q, dlm_q, ier_q, fcr_q, lcr_q, mcr_q, spr_q;
  logic [DW-1:0] ext_rdata, lsr;
  logic [MODEM_W-1:0] modem_sync;
  logic       dlab, lock, ext_rd_en, soft_rst, win_rd;
  hstrobe_t   stb;

  assign dlab = lcr_q[LCR_DLAB];
  assign lock = (lcr_q == LCR_LOCK);

  uart_rb_decode u_decode (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .dlab_i (dlab),
    .lock_i (lock),
    .stb_o  (stb)
  );

  uart_rb_ext #(.LEVEL_W(LEVEL_W)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (stb.win),
    .off_i      (spr_q),
    .wdata_i    (wdata_i),
    .rfl_i      (rfl_i),
    .tfl_i      (tfl_i),
    .rdata_o    (ext_rdata),
    .rd_en_o    (ext_rd_en),
    .cpr_o      (prescale_o),
    .cks_o      (clk_sel_o),
    .soft_rst_o (soft_rst)
  );

  uart_rb_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_modem_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (modem_ni),
    .q_o    (modem_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q <= DLL_RST;
      dlm_q <= '0;
      ier_q <= '0;
      fcr_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
    end else if (soft_rst) begin
      dll_q <= DLL_RST;
      dlm_q <= '0;
      ier_q <= '0;
      fcr_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
    end else begin
      if (stb.dll) dll_q <= wdata_i;
      if (stb.dlm) dlm_q <= wdata_i;
      if (stb.ier) ier_q <= wdata_i;
      if (stb.fcr) fcr_q <= wdata_i;
      if (stb.lcr) lcr_q <= wdata_i;
      if (stb.mcr) mcr_q <= wdata_i;
      if (stb.spr) spr_q <= wdata_i;
    end
  end

  assign lsr    = {1'b0, thr_empty_i & tsr_empty_i, thr_empty_i, 4'b0000, rx_ready_i};
  assign win_rd = ext_rd_en && !lock;

  always_comb begin
    case (host_addr_e'(addr_i))
      A_DATA:  rdata_o = dlab ? dll_q : rx_data_i;
      A_IER:   rdata_o = dlab ? dlm_q : ier_q;
      A_ISR:   rdata_o = {7'b0, ~irq_i};
      A_LCR:   rdata_o = lcr_q;
      A_MCR:   rdata_o = mcr_q;
      A_WIN:   rdata_o = win_rd ? ext_rdata : lsr;
      A_MSR:   rdata_o = {~modem_sync, {MSR_PAD{1'b0}}};
      default: rdata_o = spr_q;
    endcase
  end

  assign tx_wr_o    = stb.tx;
  assign rx_rd_o    = stb.rx;
  assign sout_o     = tx_serial_i & ~lcr_q[LCR_BRK];
  assign dtr_o      = ~mcr_q[0];
  assign rts_o      = ~mcr_q[1];
  assign divisor_o  = {dlm_q, dll_q};
  assign line_ctl_o = lcr_q;
  assign fifo_ctl_o = fcr_q;
  assign int_en_o   = ier_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        irq_i,
  input logic        dtr_o,
  input logic        tx_wr_o,
  input logic [15:0] divisor_o,
  input logic [7:0]  prescale_o,
  input logic [7:0]  clk_sel_o,
  input logic [7:0]  line_ctl_o,
  input logic        soft_rst
);
  p_isr_view_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 3'd2 |-> rdata_o == {7'b0, !irq_i});

  p_tx_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |-> wr_i && addr_i == 3'd0 && !line_ctl_o[7]);

  p_lock_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd5 && line_ctl_o == 8'hBF |=> $stable(clk_sel_o) && $stable(prescale_o));

  p_clk_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> $stable(clk_sel_o));

  p_soft_vals_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> prescale_o == 8'h20 && divisor_o == 16'h0001 && line_ctl_o == 8'h00);

  p_dtr_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd4 |=> dtr_o == !$past(wdata_i[0]));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_i      (irq_i),
  .dtr_o      (dtr_o),
  .tx_wr_o    (tx_wr_o),
  .divisor_o  (divisor_o),
  .prescale_o (prescale_o),
  .clk_sel_o  (clk_sel_o),
  .line_ctl_o (line_ctl_o),
  .soft_rst   (soft_rst)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_ready = 1'b0, thr_empty = 1'b1, tsr_empty = 1'b1, irq = 1'b0;
  logic [6:0]  rfl = '0, tfl = '0;
  logic [3:0]  modem_n = 4'hF;
  logic        tx_serial = 1'b1;
  logic        tx_wr, rx_rd, sout, dtr, rts;
  logic [15:0] divisor;
  logic [7:0]  prescale, clk_sel, line_ctl, fifo_ctl, int_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .thr_empty_i(thr_empty), .tsr_empty_i(tsr_empty), .irq_i(irq), .rfl_i(rfl),
    .tfl_i(tfl), .modem_ni(modem_n), .tx_serial_i(tx_serial), .tx_wr_o(tx_wr),
    .rx_rd_o(rx_rd), .sout_o(sout), .dtr_o(dtr), .rts_o(rts), .divisor_o(divisor),
    .prescale_o(prescale), .clk_sel_o(clk_sel), .line_ctl_o(line_ctl),
    .fifo_ctl_o(fifo_ctl), .int_en_o(int_en)
  );

  // {read, addr[2:0], data[7:0] (write data or expected), req[3:0]}
  localparam int NV = 34;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd5, 8'h60, 4'd2},  // R2 idle line status
    {1'b1, 3'd2, 8'h01, 4'd2},  // R2 no interrupt
    {1'b1, 3'd3, 8'h00, 4'd1},  // R1
    {1'b0, 3'd3, 8'h80, 4'd0},
    {1'b1, 3'd0, 8'h01, 4'd1},  // R1 divisor low reset
    {1'b1, 3'd1, 8'h00, 4'd1},
    {1'b0, 3'd0, 8'h34, 4'd0},
    {1'b0, 3'd1, 8'h12, 4'd0},
    {1'b1, 3'd0, 8'h34, 4'd4},  // R4
    {1'b1, 3'd1, 8'h12, 4'd4},
    {1'b0, 3'd3, 8'h03, 4'd0},
    {1'b0, 3'd1, 8'h05, 4'd0},
    {1'b1, 3'd1, 8'h05, 4'd4},  // R4 interrupt enable
    {1'b0, 3'd7, 8'h00, 4'd0},
    {1'b0, 3'd5, 8'h40, 4'd0},
    {1'b0, 3'd7, 8'h01, 4'd0},
    {1'b1, 3'd5, 8'h20, 4'd1},  // R1 prescaler reset
    {1'b0, 3'd7, 8'h08, 4'd0},
    {1'b1, 3'd5, 8'h01, 4'd3},  // R3
    {1'b0, 3'd7, 8'h09, 4'd0},
    {1'b1, 3'd5, 8'h02, 4'd3},
    {1'b0, 3'd7, 8'h0B, 4'd0},
    {1'b1, 3'd5, 8'h00, 4'd3},
    {1'b0, 3'd7, 8'h07, 4'd0},
    {1'b1, 3'd5, 8'h00, 4'd3},
    {1'b0, 3'd7, 8'h03, 4'd0},
    {1'b0, 3'd5, 8'hA5, 4'd0},
    {1'b1, 3'd5, 8'hA5, 4'd5},  // R5
    {1'b0, 3'd7, 8'h00, 4'd0},
    {1'b0, 3'd5, 8'h00, 4'd0},
    {1'b1, 3'd5, 8'h60, 4'd6},  // R6 window closed
    {1'b0, 3'd7, 8'hAA, 4'd0},
    {1'b1, 3'd7, 8'hAA, 4'd5},
    {1'b0, 3'd7, 8'h00, 4'd0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2;
    check(tag, {8'h00, rdata}, {8'h00, exp});
    rd = 1'b0;
  endtask

  task automatic ext_rd(input string tag, input logic [7:0] off, input logic [7:0] exp);
    wr_reg(3'd7, off);
    rd_chk(tag, 3'd5, exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset pins", {13'b0, sout, dtr, rts}, 16'h0007);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) rd_chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][14:12], VEC[i][11:4]);
      else wr_reg(VEC[i][14:12], VEC[i][11:4]);
    end

    // R5 lock code refuses window write; R6 lock hides the window
    wr_reg(3'd7, 8'h00); wr_reg(3'd5, 8'h40);
    wr_reg(3'd3, 8'hBF);
    rd_chk("R6 locked read", 3'd5, 8'h60);
    wr_reg(3'd7, 8'h03); wr_reg(3'd5, 8'h11);
    wr_reg(3'd3, 8'h03);
    ext_rd("R5 locked write ignored", 8'h03, 8'hA5);

    // R9 modem pins and break gate
    wr_reg(3'd4, 8'h03);
    #1 check("R9 pins asserted", {14'b0, dtr, rts}, 16'h0000);
    wr_reg(3'd3, 8'h43);
    #1 check("R9 break", {15'b0, sout}, 16'h0000);
    wr_reg(3'd3, 8'h03);
    tx_serial = 1'b0;
    #1 check("R9 serial pass", {15'b0, sout}, 16'h0000);
    tx_serial = 1'b1;

    // R8 nonzero write to reset register does nothing, zero write resets
    wr_reg(3'd7, 8'h04); wr_reg(3'd5, 8'h44);
    wr_reg(3'd7, 8'h01); wr_reg(3'd5, 8'h33);
    wr_reg(3'd7, 8'h07); wr_reg(3'd5, 8'h01);
    ext_rd("R8 nonzero ignored", 8'h01, 8'h33);
    wr_reg(3'd7, 8'h07); wr_reg(3'd5, 8'h00);
    #1 check("R8 pins after reset", {14'b0, dtr, rts}, 16'h0003);
    check("R8 prescaler", {8'h00, prescale}, 16'h0020);
    rd_chk("R8 window closed", 3'd5, 8'h60);
    wr_reg(3'd7, 8'h00); wr_reg(3'd5, 8'h40);
    ext_rd("R8 clock alt kept", 8'h04, 8'h44);
    ext_rd("R8 clock sel kept", 8'h03, 8'hA5);
    ext_rd("R8 prescaler reset", 8'h01, 8'h20);
    rd_chk("R8 scratch", 3'd7, 8'h01);

    // R7 options register reset
    wr_reg(3'd3, 8'h80); wr_reg(3'd0, 8'h77); wr_reg(3'd3, 8'h03);
    check("R4 divisor out", divisor, 16'h0077);
    wr_reg(3'd7, 8'h0A); wr_reg(3'd5, 8'h80);
    check("R7 divisor reset", divisor, 16'h0001);
    check("R7 clock sel kept", {8'h00, clk_sel}, 16'h00A5);
    rd_chk("R7 line ctl", 3'd3, 8'h00);

    // R3 levels
    wr_reg(3'd7, 8'h00); wr_reg(3'd5, 8'h40);
    rfl = 7'h55; tfl = 7'h0C;
    ext_rd("R3 rx level", 8'h05, 8'h55);
    ext_rd("R3 tx level", 8'h06, 8'h0C);
    ext_rd("R3 undefined", 8'hF0, 8'h00);

    // R2 line status variants
    wr_reg(3'd7, 8'h00); wr_reg(3'd5, 8'h00);
    thr_empty = 1'b0; rx_ready = 1'b1;
    rd_chk("R2 busy rx", 3'd5, 8'h01);
    thr_empty = 1'b1; tsr_empty = 1'b0; rx_ready = 1'b0;
    rd_chk("R2 shifting", 3'd5, 8'h20);
    tsr_empty = 1'b1; irq = 1'b1;
    rd_chk("R2 irq", 3'd2, 8'h00);
    irq = 1'b0;

    // R4 data path strobes
    rx_data = 8'h5A;
    @(negedge clk);
    addr = 3'd0; rd = 1'b1;
    #2 check("R4 rx read", {7'b0, rx_rd, rdata}, {8'h01, 8'h5A});
    rd = 1'b0; wr = 1'b1; wdata = 8'h3C;
    #2 check("R4 tx push", {15'b0, tx_wr}, 16'h0001);
    @(negedge clk);
    wr = 1'b0;
    wr_reg(3'd3, 8'h80);
    @(negedge clk);
    addr = 3'd0; wr = 1'b1; wdata = 8'h09;
    #2 check("R4 no push under dlab", {15'b0, tx_wr}, 16'h0000);
    @(negedge clk);
    wr = 1'b0;
    wr_reg(3'd3, 8'h03);

    // R10 modem status through two-stage synchroniser
    @(negedge clk);
    modem_n = 4'b0110;
    @(negedge clk);
    addr = 3'd6; #1;
    check("R10 one edge", {8'h00, rdata}, 16'h0000);
    @(negedge clk);
    #1 check("R10 two edges", {8'h00, rdata}, 16'h0090);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule